// File: doc/BRIEF.md
# Serial Byte Transceiver with Run-Time Rate Select

This block moves bytes over a two-wire asynchronous serial link. Every frame has the same shape: a low start bit, eight data bits sent least-significant bit first, no parity, and one high stop bit. Between frames the line rests high. The receive path watches the incoming line. It re-centres on each start edge and samples every following bit in the middle of its period. It then hands the byte to the user with a one-cycle completion pulse. The transmit path takes a parallel byte on a one-cycle strobe, drives the complete frame on its output pin, and holds a busy flag until the stop bit has ended.

The bit period comes from dividing the system clock. The clock frequency is a parameter, and three preset rates are derived from it. A 2-bit input chooses among these rates at run time. A new choice is applied only when neither path is moving a frame, so a frame that has already started always ends at the rate it began with. After reset the slowest preset rate is in use.

Top module: `uart8n1_xcvr`

## Requirements
- R1: While reset is held and on the first cycle after it, `ser_out` is 1, and `tx_busy`, `rx_valid`, `rx_ferr` and `rx_byte` are all 0.
- R2: The edge that accepts `tx_go` drives `ser_out` low for the start bit. Data bit k (bit 0 first) is driven from edge k·D+D, and the high stop bit from edge 9·D. Here D is the active divisor.
- R3: `tx_busy` rises on the accepting edge and falls exactly 10·D edges later. Whenever `tx_busy` is 0, `ser_out` is 1.
- R4: A `tx_go` pulse while `tx_busy` is 1 is ignored: the running frame is unchanged and no further frame follows it.
- R5: A frame on `ser_in` is stored LSB first. `rx_valid` is a one-cycle pulse after edge 3 + floor(D/2) + 9·D, where the first edge that samples the low start bit is edge 1. `rx_byte` carries the byte from that cycle on.
- R6: A low pulse on `ser_in` that is over before the middle of the start bit returns the receiver to idle and produces neither `rx_valid` nor `rx_ferr`.
- R7: If the stop bit samples low, `rx_ferr` pulses in the cycle where `rx_valid` would have pulsed, `rx_valid` stays 0, and `rx_byte` keeps its previous value.
- R8: `rate_sel` codes: 2'b00 gives 1.2 MBaud, 2'b01 gives 1.5 MBaud, 2'b10 gives 2 MBaud, and 2'b11 gives 1.2 MBaud. D = round(CLK_HZ / rate), which is 208, 167 and 125 at 250 MHz. Reset selects 1.2 MBaud.
- R9: A change of `rate_sel` takes effect only on an edge where both paths are idle. A frame in progress keeps its starting divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Bit-rate choice |
| ser_in | input | 1 | Incoming serial line (asynchronous) |
| rx_byte | output | 8 | Last byte received without error |
| rx_valid | output | 1 | One-cycle pulse: a byte has arrived |
| rx_ferr | output | 1 | One-cycle pulse: the stop bit was low |
| tx_byte | input | 8 | Byte to send |
| tx_go | input | 1 | Send strobe, taken only while idle |
| tx_busy | output | 1 | High while a frame is being sent |
| ser_out | output | 1 | Outgoing serial line |

## Verification
Every result has a fixed due cycle, counted in clock edges from the stimulus. On the transmit side, the start bit appears on the accepting edge, bit k at (k+1)·D, the stop bit at 9·D, and `tx_busy` falls at 10·D. The bench samples `ser_out` in the middle of each bit and checks `tx_busy` on both sides of its falling edge. On the receive side, the two synchroniser stages and the edge detector add three edges before the half-bit wait, so `rx_valid` or `rx_ferr` is due after edge 3 + floor(D/2) + 9·D. The bench checks the output low one cycle before that edge, high on it, and low again one cycle after. All sampling happens on the falling clock edge, and the bench keeps its own count of edges, so no check depends on the order of events within a clock edge.

// File: rtl/uart_pkg.sv
package uart_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // nearest-integer clock divisor for a bit rate
  function automatic int unsigned rate_div(input int unsigned clk_hz, input int unsigned baud);
    return (clk_hz + baud / 2) / baud;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/uart_rate_ctl.sv
module uart_rate_ctl
  import uart_pkg::*;
#(
  parameter int unsigned CLK_HZ = 250_000_000,
  parameter int unsigned RATE_0 = 1_200_000,
  parameter int unsigned RATE_1 = 1_500_000,
  parameter int unsigned RATE_2 = 2_000_000,
  parameter int          CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel_i,
  input  logic             rx_idle_i,
  input  logic             tx_idle_i,
  output logic [CNT_W-1:0] div_o
);
  localparam logic [CNT_W-1:0] DIV_0 = CNT_W'(rate_div(CLK_HZ, RATE_0));
  localparam logic [CNT_W-1:0] DIV_1 = CNT_W'(rate_div(CLK_HZ, RATE_1));
  localparam logic [CNT_W-1:0] DIV_2 = CNT_W'(rate_div(CLK_HZ, RATE_2));

  logic [CNT_W-1:0] pick;

  always_comb begin
    case (sel_i)
      2'b01:   pick = DIV_1;
      2'b10:   pick = DIV_2;
      default: pick = DIV_0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                        div_o <= DIV_0;
    else if (rx_idle_i && tx_idle_i) div_o <= pick;
  end

  // R9: divisor moves only after an edge where both paths were idle
  assert_div_change_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_o) |-> $past(rx_idle_i && tx_idle_i));

endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] div_i,
  input  logic             line_i,
  output logic [7:0]       byte_o,
  output logic             valid_o,
  output logic             ferr_o,
  output logic             idle_o
);
  logic [1:0]       sync_q;
  logic             prev_q;
  rx_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic             line_s;

  assign line_s = sync_q[1];
  assign idle_o = (st_q == RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b11;
      prev_q  <= 1'b1;
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], line_i};
      prev_q  <= line_s;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      if (st_q == RX_IDLE) begin
        if (prev_q && !line_s) begin
          st_q  <= RX_START;
          cnt_q <= (div_i >> 1) - CNT_W'(1);
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end else begin
        cnt_q <= div_i - CNT_W'(1);
        case (st_q)
          RX_START: begin
            if (line_s) st_q <= RX_IDLE;   // glitch, not a start bit
            else begin
              st_q  <= RX_DATA;
              bit_q <= '0;
            end
          end
          RX_DATA: begin
            sh_q  <= {line_s, sh_q[7:1]};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) st_q <= RX_STOP;
          end
          RX_STOP: begin
            st_q <= RX_IDLE;
            if (line_s) begin
              byte_o  <= sh_q;
              valid_o <= 1'b1;
            end else begin
              ferr_o <= 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  // R5: completion is a single-cycle pulse
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R7: a frame ends either good or bad, never both
  assert_valid_ferr_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && ferr_o));
  // R7: a bad stop bit leaves the held byte alone
  assert_ferr_keeps_byte_R7: assert property (@(posedge clk) disable iff (rst)
    ferr_o |-> $stable(byte_o));

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] div_i,
  input  logic [7:0]       byte_i,
  input  logic             go_i,
  output logic             busy_o,
  output logic             line_o,
  output logic             idle_o
);
  logic [8:0]       sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       bit_q;

  assign idle_o = !busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      line_o <= 1'b1;
      sh_q   <= '1;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else if (!busy_o) begin
      if (go_i) begin
        busy_o <= 1'b1;
        line_o <= 1'b0;
        sh_q   <= {1'b1, byte_i};
        cnt_q  <= div_i - CNT_W'(1);
        bit_q  <= '0;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else begin
      cnt_q <= div_i - CNT_W'(1);
      if (bit_q == 4'd9) begin
        busy_o <= 1'b0;
      end else begin
        line_o <= sh_q[0];
        sh_q   <= {1'b1, sh_q[8:1]};
        bit_q  <= bit_q + 4'd1;
      end
    end
  end

  // R3: line rests high whenever the path is idle
  assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> line_o);
  // R2: a frame opens with the low start bit
  assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !line_o);
  // R4: the byte is taken only on the edge where busy rises
  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(sh_q) || (cnt_q == div_i - CNT_W'(1)));

endmodule

// File: rtl/uart8n1_xcvr.sv
module uart8n1_xcvr
  import uart_pkg::*;
#(
  parameter int unsigned CLK_HZ = 250_000_000,
  parameter int unsigned RATE_0 = 1_200_000,
  parameter int unsigned RATE_1 = 1_500_000,
  parameter int unsigned RATE_2 = 2_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic       ser_in,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_ferr,
  input  logic [7:0] tx_byte,
  input  logic       tx_go,
  output logic       tx_busy,
  output logic       ser_out
);
  localparam int unsigned DIV_MAX = max3(rate_div(CLK_HZ, RATE_0),
                                         rate_div(CLK_HZ, RATE_1),
                                         rate_div(CLK_HZ, RATE_2));
  localparam int CNT_W = $clog2(DIV_MAX + 1);

  logic [CNT_W-1:0] div;
  logic             rx_idle;
  logic             tx_idle;

  uart_rate_ctl #(
    .CLK_HZ(CLK_HZ), .RATE_0(RATE_0), .RATE_1(RATE_1), .RATE_2(RATE_2), .CNT_W(CNT_W)
  ) u_rate (
    .clk(clk), .rst(rst), .sel_i(rate_sel),
    .rx_idle_i(rx_idle), .tx_idle_i(tx_idle), .div_o(div)
  );

  uart_rx_path #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .div_i(div), .line_i(ser_in),
    .byte_o(rx_byte), .valid_o(rx_valid), .ferr_o(rx_ferr), .idle_o(rx_idle)
  );

  uart_tx_path #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .div_i(div), .byte_i(tx_byte), .go_i(tx_go),
    .busy_o(tx_busy), .line_o(ser_out), .idle_o(tx_idle)
  );

endmodule

// File: tb/uart8n1_xcvr_tb.sv
`timescale 1ns/1ps
module uart8n1_xcvr_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rate_sel = 2'b00;
  logic       ser_in = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_go = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_ferr, tx_busy, ser_out;

  int n_chk = 0;
  int n_bad = 0;
  int cur   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  uart8n1_xcvr u_dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .ser_in(ser_in),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ferr(rx_ferr),
    .tx_byte(tx_byte), .tx_go(tx_go), .tx_busy(tx_busy), .ser_out(ser_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // from the negedge after relative edge cur, move to negedge after edge n
  task automatic go_to(input int n);
    repeat (n - cur) @(posedge clk);
    @(negedge clk);
    cur = n;
  endtask

  task automatic set_rate(input logic [1:0] s);
    @(negedge clk);
    rate_sel = s;
    repeat (4) @(negedge clk);
  endtask

  // R1
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ser_out", ser_out, 1);
    check("R1 tx_busy", tx_busy, 0);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 rx_ferr", rx_ferr, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rx_byte", rx_byte, 0);
    check("R1 ser_out after release", ser_out, 1);
  endtask

  // R2/R3 (R4 when poke, R9 when new_sel differs)
  task automatic t_tx(input logic [7:0] b, input int d, input bit poke,
                      input logic [1:0] new_sel, input bit change);
    logic [9:0] frame;
    frame = {1'b1, b, 1'b0};
    @(negedge clk);
    tx_byte = b;
    tx_go   = 1'b1;
    cur = -1;
    go_to(0);
    tx_go = 1'b0;
    check("R2 start bit", ser_out, 0);
    check("R3 busy rises", tx_busy, 1);
    if (change) rate_sel = new_sel;
    for (int k = 0; k < 10; k++) begin
      go_to(k * d + d / 2);
      check($sformatf("R2 bit %0d", k), ser_out, frame[k]);
      if (poke && k == 3) begin
        tx_byte = ~b;
        tx_go   = 1'b1;
        go_to(cur + 1);
        tx_go = 1'b0;
      end
    end
    go_to(10 * d - 1);
    check("R3 busy before end", tx_busy, 1);
    go_to(10 * d);
    check("R3 busy falls", tx_busy, 0);
    check("R3 idle high", ser_out, 1);
    if (poke) begin
      go_to(12 * d);
      check("R4 no second frame busy", tx_busy, 0);
      check("R4 no second frame line", ser_out, 1);
    end
  endtask

  // R5/R7: drive a frame on ser_in, check the result on its due cycle
  task automatic t_rx(input logic [7:0] b, input bit stop, input int d);
    logic [9:0] frame;
    logic [7:0] held;
    int due;
    held  = rx_byte;
    frame = {stop, b, 1'b0};
    due   = 3 + d / 2 + 9 * d;
    @(negedge clk);
    cur = 0;
    for (int k = 0; k < 10; k++) begin
      go_to(k * d);
      ser_in = frame[k];
      if (k == 9) begin
        go_to(due - 1);
        check("R5 valid not early", rx_valid, 0);
        check("R7 ferr not early", rx_ferr, 0);
        go_to(due);
        if (stop) begin
          check("R5 valid pulse", rx_valid, 1);
          check("R5 byte", rx_byte, b);
          check("R7 no ferr on good stop", rx_ferr, 0);
        end else begin
          check("R7 ferr pulse", rx_ferr, 1);
          check("R7 no valid", rx_valid, 0);
          check("R7 byte kept", rx_byte, held);
        end
        go_to(due + 1);
        check("R5 valid one cycle", rx_valid, 0);
        check("R7 ferr one cycle", rx_ferr, 0);
      end
    end
    go_to(10 * d);
    ser_in = 1'b1;
    go_to(12 * d);
  endtask

  // R6
  task automatic t_glitch(input int d);
    int seen;
    seen = 0;
    @(negedge clk);
    ser_in = 1'b0;
    repeat (3) @(negedge clk);
    ser_in = 1'b1;
    for (int i = 0; i < 12 * d; i++) begin
      @(negedge clk);
      if (rx_valid || rx_ferr) seen++;
    end
    check("R6 glitch ignored", seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    // R8: reset default is 1.2 MBaud, D=208
    t_tx(8'hA5, 208, 1'b0, 2'b00, 1'b0);
    set_rate(2'b01);                         // R8 1.5 MBaud
    t_tx(8'h3C, 167, 1'b0, 2'b00, 1'b0);
    set_rate(2'b10);                         // R8 2 MBaud
    t_tx(8'h81, 125, 1'b0, 2'b00, 1'b0);
    set_rate(2'b11);                         // R8 fallback code
    t_tx(8'h5A, 208, 1'b0, 2'b00, 1'b0);
    t_tx(8'hC3, 208, 1'b1, 2'b00, 1'b0);     // R4 poke while busy
    // R9: change while busy, running frame keeps D=208
    set_rate(2'b00);
    t_tx(8'h96, 208, 1'b0, 2'b10, 1'b1);
    repeat (4) @(negedge clk);
    t_tx(8'h69, 125, 1'b0, 2'b00, 1'b0);     // R9 next frame at new rate
    set_rate(2'b00);
    t_rx(8'hB4, 1'b1, 208);                  // R5
    set_rate(2'b01);
    t_rx(8'h1E, 1'b1, 167);                  // R5 at 1.5 MBaud
    set_rate(2'b10);
    t_rx(8'hF0, 1'b1, 125);                  // R5 at 2 MBaud
    t_rx(8'h0F, 1'b0, 125);                  // R7 bad stop bit
    t_glitch(125);                           // R6
    t_rx(8'h7E, 1'b1, 125);                  // R5 receiver recovered
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule